// File: doc/BRIEF.md
# Audio Sample Packing FIFO

This block accepts one pair of microphone samples (left and right, 24-bit signed) per sample strobe. It routes them through a source selector, packs them into 32-bit words using one of four packing modes, and queues the words in a 128-entry FIFO. A host or DMA engine reads the FIFO through a fall-through read port.

The block derives three flags from the FIFO:

- **not empty**, taken directly from the level.
- **threshold reached**, decoded from a programmable threshold code.
- **overrun**, which is sticky.

Each flag has its own interrupt enable, and all enabled flags combine into one interrupt line. The threshold flag can also drive a wake output. It can also be routed to the DMA request in place of a default request input.

A run control holds the FIFO and the packer in reset until software switches the block to operational. Reset is the state after power-on. Configuration is expected to change only while the block is held.

Top module: `audio_pack_fifo`

## Requirements
- R1: While run_i is 0 (the default after reset), the FIFO level is 0, incoming samples produce no words, the sticky overrun flag is cleared and any half-packed word is discarded.
- R2: With pack_mode_i = 0, two consecutive samples of the left channel form one word. The earlier sample's low 16 bits go to bits 15:0 and the later sample's low 16 bits go to bits 31:16. The word is queued on the clock edge that takes the second sample.
- R3: With pack_mode_i = 1, each sample strobe queues one word with the left channel's low 16 bits in bits 15:0 and the right channel's low 16 bits in bits 31:16.
- R4: With pack_mode_i = 2, each sample strobe queues one word holding the 24-bit left channel in bits 23:0, sign-extended into bits 31:24.
- R5: With pack_mode_i = 3, each sample strobe queues two sign-extended 24-bit words on consecutive clock edges, left first, then right. Strobes must be at least two cycles apart in this mode.
- R6: src_sel_i selects the channels fed to the packer:
  - 0: both channels carry left.
  - 1: both channels carry right.
  - 2: both channels carry floor((left + right) / 2), computed without overflow.
  - 3: left and right pass through unchanged.
- R7: Words leave in the order they were queued. rd_data_o shows the oldest word, and rd_en_i with the FIFO non-empty removes it. nempty_o is 1 exactly when level_o is non-zero.
- R8: thr_o is 1 when level_o is at least the threshold word count. Code 0 means 1 word, and code c > 0 means 2*c words. The codes 0, 1, 2, 4, 8, 16, 20, 32, 40 and 48 give 1, 2, 4, 8, 16, 32, 40, 64, 80 and 96 words.
- R9: A word completed while level_o equals 128 is dropped, leaving the FIFO contents unchanged, and sets ovr_o. ovr_o stays set until the block is held by R1.
- R10: irq_o is the OR of the three flags (not empty, threshold, overrun), each gated by its own enable. wake_o is thr_o gated by wake_en_i.
- R11: dma_req_o follows thr_o when dma_sel_i is 1 and follows dma_dflt_i when dma_sel_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 = operational, 0 = FIFO and packer held in reset |
| src_sel_i | input | 2 | Microphone source select |
| pack_mode_i | input | 2 | Packing mode |
| thr_code_i | input | 6 | Threshold code (half the word count, 0 = one word) |
| smp_valid_i | input | 1 | Sample strobe |
| left_i | input | 24 | Left sample, signed |
| right_i | input | 24 | Right sample, signed |
| rd_en_i | input | 1 | Pop the oldest word |
| rd_data_o | output | 32 | Oldest word |
| level_o | output | 8 | Words held |
| nempty_o | output | 1 | FIFO not empty |
| thr_o | output | 1 | Threshold reached |
| ovr_o | output | 1 | Sticky overrun |
| ie_nempty_i | input | 1 | Interrupt enable, not empty |
| ie_thr_i | input | 1 | Interrupt enable, threshold |
| ie_ovr_i | input | 1 | Interrupt enable, overrun |
| wake_en_i | input | 1 | Wake enable for the threshold flag |
| dma_sel_i | input | 1 | 1 = threshold drives the DMA request |
| dma_dflt_i | input | 1 | Default DMA request |
| irq_o | output | 1 | Combined interrupt |
| wake_o | output | 1 | Wake request |
| dma_req_o | output | 1 | DMA request |

## Verification
Each packing mode is tried with left and right values that differ in their upper byte and sign. A word in the wrong half, a missing sign extension or a swapped channel therefore shows up as a wrong bit pattern.

The source selector is tried with left-only, right-only and mono routing, using a negative odd sum. This separates a floor average from a truncating one, and detects an average that wraps.

The FIFO is filled to exactly one below and at the threshold for several codes. It is also filled to one past capacity, which shows whether the dropped word is the new one and whether the overrun flag stays set after a read.

// File: rtl/audio_pack_pkg.sv
package audio_pack_pkg;
  localparam int SMP_W  = 24;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SRC_LEFT   = 2'd0,
    SRC_RIGHT  = 2'd1,
    SRC_MONO   = 2'd2,
    SRC_STEREO = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    PK_L16X2 = 2'd0,
    PK_LR16  = 2'd1,
    PK_L24   = 2'd2,
    PK_LR24  = 2'd3
  } pack_e;
endpackage

// File: rtl/aps_src_mux.sv
module aps_src_mux
  import audio_pack_pkg::*;
#(
  parameter int SW = SMP_W
) (
  input  src_e          sel_i,
  input  logic [SW-1:0] l_i,
  input  logic [SW-1:0] r_i,
  output logic [SW-1:0] l_o,
  output logic [SW-1:0] r_o
);
  logic [SW:0] sum;
  logic [SW-1:0] avg;

  // one bit of headroom, arithmetic halving (floor)
  assign sum = {l_i[SW-1], l_i} + {r_i[SW-1], r_i};
  assign avg = sum[SW:1];

  always_comb begin
    unique case (sel_i)
      SRC_LEFT:  begin l_o = l_i; r_o = l_i; end
      SRC_RIGHT: begin l_o = r_i; r_o = r_i; end
      SRC_MONO:  begin l_o = avg; r_o = avg; end
      default:   begin l_o = l_i; r_o = r_i; end
    endcase
  end
endmodule

// File: rtl/aps_packer.sv
module aps_packer
  import audio_pack_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int WW = WORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  pack_e         mode_i,
  input  logic          smp_valid_i,
  input  logic [SW-1:0] l_i,
  input  logic [SW-1:0] r_i,
  output logic          word_valid_o,
  output logic [WW-1:0] word_o
);
  localparam int HW = WW / 2;
  localparam int XW = WW - SW;

  logic [HW-1:0] held_q;
  logic          have_half_q;
  logic [WW-1:0] pend_q;
  logic          pend_v_q;
  logic [WW-1:0] l_ext, r_ext;

  assign l_ext = {{XW{l_i[SW-1]}}, l_i};
  assign r_ext = {{XW{r_i[SW-1]}}, r_i};

  always_comb begin
    word_valid_o = 1'b0;
    word_o       = '0;
    if (pend_v_q) begin
      word_valid_o = 1'b1;
      word_o       = pend_q;
    end else if (smp_valid_i) begin
      unique case (mode_i)
        PK_L16X2: begin
          word_valid_o = have_half_q;
          word_o       = {l_i[HW-1:0], held_q};
        end
        PK_LR16: begin
          word_valid_o = 1'b1;
          word_o       = {r_i[HW-1:0], l_i[HW-1:0]};
        end
        default: begin
          word_valid_o = 1'b1;
          word_o       = l_ext;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q      <= '0;
      have_half_q <= 1'b0;
      pend_q      <= '0;
      pend_v_q    <= 1'b0;
    end else if (clr_i) begin
      held_q      <= '0;
      have_half_q <= 1'b0;
      pend_q      <= '0;
      pend_v_q    <= 1'b0;
    end else begin
      pend_v_q <= 1'b0;
      if (smp_valid_i && !pend_v_q) begin
        if (mode_i == PK_LR24) begin
          pend_q   <= r_ext;
          pend_v_q <= 1'b1;
        end
        if (mode_i == PK_L16X2) begin
          if (have_half_q) begin
            have_half_q <= 1'b0;
          end else begin
            held_q      <= l_i[HW-1:0];
            have_half_q <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/aps_fifo.sv
module aps_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_nx, rp_nx;
  logic [LW-1:0] lvl_q;
  logic          wr, rd;

  assign full_o  = (lvl_q == LW'(DEPTH));
  assign wr      = push_i && !full_o;
  assign rd      = pop_i && (lvl_q != '0);
  assign rdata_o = mem[rp_q];
  assign level_o = lvl_q;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wp_nx = wp_q + 1'b1;
      assign rp_nx = rp_q + 1'b1;
    end else begin : g_wrap
      assign wp_nx = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      assign rp_nx = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (wr) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (wr) wp_q <= wp_nx;
      if (rd) rp_q <= rp_nx;
      unique case ({wr, rd})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end
endmodule

// File: rtl/aps_status.sv
module aps_status #(
  parameter int LW  = 8,
  parameter int THW = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic [LW-1:0]  level_i,
  input  logic [THW-1:0] thr_code_i,
  input  logic           ovr_set_i,
  input  logic           ie_nempty_i,
  input  logic           ie_thr_i,
  input  logic           ie_ovr_i,
  input  logic           wake_en_i,
  input  logic           dma_sel_i,
  input  logic           dma_dflt_i,
  output logic           nempty_o,
  output logic           thr_o,
  output logic           ovr_o,
  output logic           irq_o,
  output logic           wake_o,
  output logic           dma_req_o
);
  logic [31:0] thr_words, lvl_ext;
  logic        ovr_q;

  // code 0 -> one word, otherwise twice the code
  assign thr_words = (thr_code_i == '0) ? 32'd1 : {31'(thr_code_i), 1'b0};
  assign lvl_ext   = 32'(level_i);

  assign nempty_o  = (level_i != '0);
  assign thr_o     = (lvl_ext >= thr_words);
  assign ovr_o     = ovr_q;
  assign irq_o     = (nempty_o & ie_nempty_i) | (thr_o & ie_thr_i) | (ovr_q & ie_ovr_i);
  assign wake_o    = thr_o & wake_en_i;
  assign dma_req_o = dma_sel_i ? thr_o : dma_dflt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (clr_i)     ovr_q <= 1'b0;
    else if (ovr_set_i) ovr_q <= 1'b1;
  end
endmodule

// File: rtl/audio_pack_fifo.sv
module audio_pack_fifo
  import audio_pack_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int THW   = 6,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [1:0]        src_sel_i,
  input  logic [1:0]        pack_mode_i,
  input  logic [THW-1:0]    thr_code_i,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  left_i,
  input  logic [SMP_W-1:0]  right_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [LW-1:0]     level_o,
  output logic              nempty_o,
  output logic              thr_o,
  output logic              ovr_o,
  input  logic              ie_nempty_i,
  input  logic              ie_thr_i,
  input  logic              ie_ovr_i,
  input  logic              wake_en_i,
  input  logic              dma_sel_i,
  input  logic              dma_dflt_i,
  output logic              irq_o,
  output logic              wake_o,
  output logic              dma_req_o
);
  logic              clr;
  logic [SMP_W-1:0]  l_rt, r_rt;
  logic              wv;
  logic [WORD_W-1:0] wd;
  logic              full;

  assign clr = !run_i;

  aps_src_mux #(.SW(SMP_W)) u_src (
    .sel_i (src_e'(src_sel_i)),
    .l_i   (left_i),
    .r_i   (right_i),
    .l_o   (l_rt),
    .r_o   (r_rt)
  );

  aps_packer #(.SW(SMP_W), .WW(WORD_W)) u_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .mode_i       (pack_e'(pack_mode_i)),
    .smp_valid_i  (smp_valid_i),
    .l_i          (l_rt),
    .r_i          (r_rt),
    .word_valid_o (wv),
    .word_o       (wd)
  );

  aps_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .push_i  (wv),
    .wdata_i (wd),
    .pop_i   (rd_en_i),
    .rdata_o (rd_data_o),
    .level_o (level_o),
    .full_o  (full)
  );

  aps_status #(.LW(LW), .THW(THW)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .level_i     (level_o),
    .thr_code_i  (thr_code_i),
    .ovr_set_i   (wv & full),
    .ie_nempty_i (ie_nempty_i),
    .ie_thr_i    (ie_thr_i),
    .ie_ovr_i    (ie_ovr_i),
    .wake_en_i   (wake_en_i),
    .dma_sel_i   (dma_sel_i),
    .dma_dflt_i  (dma_dflt_i),
    .nempty_o    (nempty_o),
    .thr_o       (thr_o),
    .ovr_o       (ovr_o),
    .irq_o       (irq_o),
    .wake_o      (wake_o),
    .dma_req_o   (dma_req_o)
  );
endmodule

// File: rtl/audio_pack_fifo_chk.sv
module audio_pack_fifo_chk #(
  parameter int DEPTH = 128,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_i,
  input logic          smp_valid_i,
  input logic [1:0]    pack_mode_i,
  input logic          rd_en_i,
  input logic [LW-1:0] level_o,
  input logic          nempty_o,
  input logic          ovr_o
);
  a_r1_held_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (level_o == '0 && !ovr_o));

  a_r7_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH));

  a_r7_nempty_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nempty_o == (level_o != '0));

  a_r9_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && ovr_o) |=> ovr_o);

  a_r9_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && level_o == LW'(DEPTH) && !rd_en_i) |=> level_o == LW'(DEPTH));

  a_r5_strobe_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && smp_valid_i && pack_mode_i == 2'd3) |=> !smp_valid_i);
endmodule

bind audio_pack_fifo audio_pack_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .smp_valid_i (smp_valid_i),
  .pack_mode_i (pack_mode_i),
  .rd_en_i     (rd_en_i),
  .level_o     (level_o),
  .nempty_o    (nempty_o),
  .ovr_o       (ovr_o)
);

// File: tb/tb_audio_pack_fifo.sv
module tb_audio_pack_fifo;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [1:0]  src_sel_i = 2'd3;
  logic [1:0]  pack_mode_i = 2'd0;
  logic [5:0]  thr_code_i = 6'd0;
  logic        smp_valid_i = 1'b0;
  logic [23:0] left_i = '0, right_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic [7:0]  level_o;
  logic        nempty_o, thr_o, ovr_o;
  logic        ie_nempty_i = 1'b0, ie_thr_i = 1'b0, ie_ovr_i = 1'b0;
  logic        wake_en_i = 1'b0, dma_sel_i = 1'b0, dma_dflt_i = 1'b0;
  logic        irq_o, wake_o, dma_req_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  audio_pack_fifo dut (.*, .clk_i(clk));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] sx(logic [23:0] v);
    return {{8{v[23]}}, v};
  endfunction

  function automatic logic [23:0] avg(logic [23:0] l, logic [23:0] r);
    logic [24:0] s;
    s = {l[23], l} + {r[23], r};
    return s[24:1];
  endfunction

  task automatic send(logic [23:0] l, logic [23:0] r);
    @(negedge clk);
    left_i = l; right_i = r; smp_valid_i = 1'b1;
    @(negedge clk);
    smp_valid_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop(string tag, logic [31:0] exp);
    @(negedge clk);
    chk(tag, rd_data_o, exp);
    rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic restart(logic [1:0] src, logic [1:0] mode);
    @(negedge clk);
    run_i = 1'b0; src_sel_i = src; pack_mode_i = mode;
    @(negedge clk);
    run_i = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 level after reset", 32'(level_o), 0);
    chk("R1 nempty after reset", 32'(nempty_o), 0);
    pack_mode_i = 2'd2;
    send(24'h000123, 24'h0);
    chk("R1 held ignores samples", 32'(level_o), 0);
    // half word discarded by hold
    restart(2'd3, 2'd0);
    send(24'h00AAAA, 24'h0);
    restart(2'd3, 2'd0);
    send(24'h001111, 24'h0);
    chk("R1 half word cleared", 32'(level_o), 0);
    send(24'h002222, 24'h0);
    pop("R1 fresh pair", 32'h2222_1111);
  endtask

  task automatic t_mode0();
    restart(2'd3, 2'd0);
    send(24'hF01234, 24'h00FFFF);
    chk("R2 one sample no word", 32'(level_o), 0);
    send(24'h0F8765, 24'h00EEEE);
    chk("R2 word queued", 32'(level_o), 1);
    pop("R2 pair order", 32'h8765_1234);
  endtask

  task automatic t_mode1();
    restart(2'd3, 2'd1);
    send(24'hAB1357, 24'hCD2468);
    send(24'h00FFFF, 24'h000001);
    chk("R3 level", 32'(level_o), 2);
    pop("R3 lr word", 32'h2468_1357);
    pop("R3 lr word 2", 32'h0001_FFFF);
  endtask

  task automatic t_mode2();
    restart(2'd3, 2'd2);
    send(24'h800001, 24'h123456);
    send(24'h7FFFFF, 24'h800000);
    pop("R4 negative sext", 32'hFF80_0001);
    pop("R4 positive sext", 32'h007F_FFFF);
  endtask

  task automatic t_mode3();
    restart(2'd3, 2'd3);
    @(negedge clk);
    left_i = 24'h123456; right_i = 24'h876543; smp_valid_i = 1'b1;
    @(negedge clk);
    smp_valid_i = 1'b0;
    chk("R5 left word first edge", 32'(level_o), 1);
    @(negedge clk);
    chk("R5 right word next edge", 32'(level_o), 2);
    pop("R5 left first", sx(24'h123456));
    pop("R5 right second", sx(24'h876543));
  endtask

  task automatic t_src();
    restart(2'd0, 2'd1);
    send(24'h001111, 24'h002222);
    pop("R6 left only", 32'h1111_1111);
    restart(2'd1, 2'd1);
    send(24'h001111, 24'h002222);
    pop("R6 right only", 32'h2222_2222);
    restart(2'd2, 2'd2);
    send(24'h000005, 24'hFFFFF8);
    pop("R6 mono floor", sx(avg(24'h000005, 24'hFFFFF8)));
    send(24'h7FFFFF, 24'h7FFFFD);
    pop("R6 mono headroom", 32'h007F_FFFE);
  endtask

  task automatic t_thr();
    restart(2'd3, 2'd2);
    thr_code_i = 6'd0;
    @(negedge clk);
    chk("R8 code0 empty", 32'(thr_o), 0);
    send(24'h1, 24'h0);
    chk("R8 code0 one word", 32'(thr_o), 1);
    restart(2'd3, 2'd2);
    thr_code_i = 6'd2;
    for (int i = 0; i < 3; i++) send(24'(i), 24'h0);
    chk("R8 code2 three words", 32'(thr_o), 0);
    send(24'h3, 24'h0);
    chk("R8 code2 four words", 32'(thr_o), 1);
    restart(2'd3, 2'd2);
    thr_code_i = 6'd48;
    for (int i = 0; i < 95; i++) send(24'(i), 24'h0);
    chk("R8 code48 95 words", 32'(thr_o), 0);
    send(24'h5F, 24'h0);
    chk("R8 code48 96 words", 32'(thr_o), 1);
    thr_code_i = 6'd0;
  endtask

  task automatic t_ovr();
    restart(2'd3, 2'd2);
    for (int i = 0; i < 128; i++) send(24'(i + 1), 24'h0);
    chk("R9 full level", 32'(level_o), 128);
    chk("R9 no overrun at full", 32'(ovr_o), 0);
    send(24'h00ABCD, 24'h0);
    chk("R9 level unchanged", 32'(level_o), 128);
    chk("R9 overrun set", 32'(ovr_o), 1);
    pop("R9 head kept", 32'h1);
    chk("R9 sticky after pop", 32'(ovr_o), 1);
    for (int i = 1; i < 127; i++) begin
      @(negedge clk); rd_en_i = 1'b1;
      @(negedge clk); rd_en_i = 1'b0;
    end
    pop("R9 tail not dropped word", 32'd128);
    restart(2'd3, 2'd2);
    chk("R9 cleared by hold", 32'(ovr_o), 0);
  endtask

  task automatic t_irq();
    restart(2'd3, 2'd2);
    thr_code_i = 6'd1;
    @(negedge clk);
    ie_nempty_i = 1'b1; ie_thr_i = 1'b1; ie_ovr_i = 1'b1; wake_en_i = 1'b1;
    @(negedge clk);
    chk("R10 irq idle", 32'(irq_o), 0);
    ie_nempty_i = 1'b0;
    send(24'h1, 24'h0);
    chk("R10 masked nempty", 32'(irq_o), 0);
    ie_nempty_i = 1'b1;
    @(negedge clk);
    chk("R10 nempty irq", 32'(irq_o), 1);
    chk("R10 wake below thr", 32'(wake_o), 0);
    ie_nempty_i = 1'b0;
    send(24'h2, 24'h0);
    chk("R10 thr irq", 32'(irq_o), 1);
    chk("R10 wake", 32'(wake_o), 1);
    wake_en_i = 1'b0; ie_thr_i = 1'b0;
    @(negedge clk);
    chk("R10 wake masked", 32'(wake_o), 0);
    chk("R10 thr masked", 32'(irq_o), 0);
    ie_ovr_i = 1'b0;
    thr_code_i = 6'd0;
  endtask

  task automatic t_dma();
    restart(2'd3, 2'd2);
    thr_code_i = 6'd0;
    dma_sel_i = 1'b0; dma_dflt_i = 1'b1;
    @(negedge clk);
    chk("R11 default route", 32'(dma_req_o), 1);
    dma_sel_i = 1'b1;
    @(negedge clk);
    chk("R11 thr route low", 32'(dma_req_o), 0);
    send(24'h9, 24'h0);
    chk("R11 thr route high", 32'(dma_req_o), 1);
    dma_sel_i = 1'b0; dma_dflt_i = 1'b0;
    @(negedge clk);
    chk("R11 default low", 32'(dma_req_o), 0);
  endtask

  task automatic t_order();
    restart(2'd3, 2'd2);
    for (int i = 0; i < 5; i++) send(24'(16 * i + 3), 24'h0);
    for (int i = 0; i < 5; i++) pop("R7 order", 32'(16 * i + 3));
    @(negedge clk);
    chk("R7 empty after reads", 32'(nempty_o), 0);
    rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    chk("R7 pop on empty", 32'(level_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_src();
    t_order();
    t_thr();
    t_ovr();
    t_irq();
    t_dma();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule